// File: doc/BRIEF.md
# Four-Bank Rotating SDRAM Read Sequencer

This block drives the command pins of an SDRAM so that single-word random reads go out at a steady rate of one every two clock cycles. Each read is paired with its own row. The four banks are used in a fixed rotation (0, 1, 2, 3, 0, ...). While one bank is being read with auto-precharge, the row of a later bank is being opened, so the activate and precharge time of each bank is hidden behind work in the other banks.

A client supplies a stream of row/column requests with a valid/ready handshake. The bank is never supplied, because the rotation implies it. A `start` pulse opens a session. A fill phase opens the first three banks. A steady phase of READ/ACTIVATE pairs follows and can run for any length of time. A `stop` pulse lets the current pair finish, then issues the reads still owed to rows that are already open and returns to idle. A slot with no request waiting becomes a hole in the schedule, and the rotation goes on around it. A read-issued strobe with the bank and column marks every READ, so that returned data can be aligned by a fixed CAS latency further downstream.

Top module: `sdram_rot_seq`

## Requirements
- R1: During reset and while idle, `cmd` is NOP (code 0), `cmd_bank` and `cmd_addr` are zero, and `req_ready` and `rd_strobe` are low.
- R2: Command codes are NOP=0, ACTIVATE=1 and READ with auto-precharge=2, and every NOP drives bank and address zero. A `start` pulse in idle opens a session. The commands that follow are ACTIVATE bank 0, NOP, ACTIVATE bank 1, NOP, ACTIVATE bank 2, and then the first READ, which goes to bank 0.
- R3: After the fill, commands alternate READ and ACTIVATE. The READ in bank b is followed by the ACTIVATE of bank (b+3) mod 4. Two READs are never adjacent, and one READ issues every two cycles for as long as requests keep coming.
- R4: An ACTIVATE appears on the clock edge after a request is accepted (`req_valid` and `req_ready` both high), with `cmd_addr` equal to that request's row. Successive ACTIVATE slots take banks 0, 1, 2, 3, 0, ... in order.
- R5: Each accepted request is read five cycles after its ACTIVATE, in the same bank and in acceptance order. `cmd_addr` carries the column in bits [8:0] and has bit 10 set to request auto-precharge.
- R6: `rd_strobe` is high exactly in the cycles where READ is driven, and in those cycles `rd_bank` and `rd_col` equal the READ's bank and column.
- R7: `req_ready` is high only in activate slots of a running session that is not draining, so it is never high in two consecutive cycles.
- R8: If no request is valid in an activate slot, that slot issues NOP and the bank in the rotation is skipped. The matching read slot five cycles later also issues NOP with no strobe. The request accepted next takes the next bank.
- R9: After `stop`, the pair in progress completes and no further ACTIVATE is issued. Every row already opened is still read in its scheduled slot. The block then goes idle, and the next session starts again at bank 0.
- R10: `start` during a session and `stop` while idle have no effect on the command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a session when idle |
| stop | input | 1 | Ends the session after the current pair |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_row | input | 13 | Row address of the offered request |
| req_col | input | 9 | Column address of the offered request |
| cmd | output | 2 | Command code: 0 NOP, 1 ACTIVATE, 2 READ with auto-precharge |
| cmd_bank | output | 2 | Bank of the command |
| cmd_addr | output | 13 | Row for ACTIVATE; column with bit 10 set for READ |
| rd_strobe | output | 1 | High in each cycle a READ is driven |
| rd_bank | output | 2 | Bank of the READ being driven |
| rd_col | output | 9 | Column of the READ being driven |

## Verification
The hardest cases to reach are a stop that arrives in a read slot rather than an activate slot, and a stop that arrives while the fill is still in progress. In both cases the drain has to keep the original five-cycle spacing instead of hurrying the open rows out. The bench raises `stop` at chosen cycles of each parity, including the first cycle of a session, and compares the whole trace against a schedule worked out from the stop cycle. A schedule hole is forced by holding back `req_valid` for exactly one ready slot in the middle of a run. A redundant `start` and an idle-time `stop` are also injected, to show that the command trace does not move.

// File: rtl/seq_rot_pkg.sv
// Package: shared command encoding for the rotating-bank read sequencer.
// Assumes a 2-bit command bus toward the memory-side pin driver.
package seq_rot_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RDA = 2'd2
    } sd_cmd_e;

endpackage

// File: rtl/seq_slot_ctrl.sv
// seq_slot_ctrl: session state for the rotating sequencer.
// Tracks whether a session runs, the slot phase (activate slot or read slot),
// whether a stop is pending or draining has begun, and the bank owed to the
// next activate slot. Assumes NUM_BANKS >= 2. Drain ends when the queue
// reports that no valid entry remains after the current cycle.
module seq_slot_ctrl #(
    parameter int NUM_BANKS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          stop,
    input  logic                          drained_next,
    output logic                          act_slot,
    output logic                          rd_slot,
    output logic                          take_ok,
    output logic                          end_run,
    output logic [$clog2(NUM_BANKS)-1:0]  act_bank
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

    logic running;
    logic phase;       // 0: activate slot, 1: read slot
    logic draining;
    logic stop_pend;
    logic [BANK_W-1:0] bank_nxt;

    // Slot qualifiers seen by the rest of the block.
    always_comb begin
        act_slot = running && !phase;
        rd_slot  = running && phase;
        take_ok  = act_slot && !draining;
        end_run  = running && draining && drained_next;
        bank_nxt = (act_bank == LAST_BANK) ? '0 : act_bank + 1'b1;
    end

    // Session, phase, stop and rotation state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            phase     <= 1'b0;
            draining  <= 1'b0;
            stop_pend <= 1'b0;
            act_bank  <= '0;
        end else if (!running) begin
            running   <= start;
            phase     <= 1'b0;
            draining  <= 1'b0;
            stop_pend <= 1'b0;
            act_bank  <= '0;
        end else if (end_run) begin
            running   <= 1'b0;
            phase     <= 1'b0;
            draining  <= 1'b0;
            stop_pend <= 1'b0;
            act_bank  <= '0;
        end else begin
            phase <= !phase;
            if (stop) begin
                stop_pend <= 1'b1;
            end
            if (!phase) begin
                act_bank <= bank_nxt;
                if (stop || stop_pend) begin
                    draining <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/seq_col_queue.sv
// seq_col_queue: in-order queue of pending reads, one entry per activate slot.
// Each entry keeps a valid flag (clear for a schedule hole), the bank and the
// column. Assumes push and pop never fall in the same cycle, and that pop is
// only requested while the queue holds entries. Flush empties it at once.
module seq_col_queue #(
    parameter int DEPTH  = 4,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        push,
    input  logic                        push_vld,
    input  logic [BANK_W-1:0]           push_bank,
    input  logic [COL_W-1:0]            push_col,
    input  logic                        pop,
    output logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        head_vld,
    output logic [BANK_W-1:0]           head_bank,
    output logic [COL_W-1:0]            head_col,
    output logic                        drained_next
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DEPTH-1:0]  vld_q;
    logic [BANK_W-1:0] bank_q [DEPTH];
    logic [COL_W-1:0]  col_q  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  vcnt;
    logic [CNT_W-1:0]  vcnt_next;

    // Head view and count of valid entries after this cycle.
    always_comb begin
        head_vld  = vld_q[rd_ptr];
        head_bank = bank_q[rd_ptr];
        head_col  = col_q[rd_ptr];
        vcnt_next = vcnt;
        if (push && push_vld) begin
            vcnt_next = vcnt_next + 1'b1;
        end
        if (pop && head_vld) begin
            vcnt_next = vcnt_next - 1'b1;
        end
        drained_next = (vcnt_next == '0);
    end

    // Entry storage, written at the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                bank_q[i] <= '0;
                col_q[i]  <= '0;
            end
        end else if (flush) begin
            vld_q <= '0;
        end else if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_ptr == PTR_W'(i)) begin
                    vld_q[i]  <= push_vld;
                    bank_q[i] <= push_bank;
                    col_q[i]  <= push_col;
                end
            end
        end
    end

    // Pointers and occupancy counters.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            vcnt   <= '0;
        end else begin
            vcnt <= vcnt_next;
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
                count  <= count + 1'b1;
            end else if (pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
                count  <= count - 1'b1;
            end
        end
    end

endmodule

// File: rtl/seq_cmd_out.sv
// seq_cmd_out: registered command stage toward the memory pins.
// Encodes ACTIVATE (row on the address bus), READ with auto-precharge
// (column in the low bits, AP_BIT set) or NOP (bank and address zero).
// Assumes do_act and do_rd are never both high, and COL_W <= AP_BIT < ADDR_W.
module seq_cmd_out
    import seq_rot_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_act,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ADDR_W-1:0] act_row,
    input  logic              do_rd,
    input  logic [BANK_W-1:0] rd_bank_in,
    input  logic [COL_W-1:0]  rd_col_in,
    output logic [1:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              rd_strobe,
    output logic [BANK_W-1:0] rd_bank,
    output logic [COL_W-1:0]  rd_col
);

    logic [ADDR_W-1:0] rd_addr;

    // READ address: column in the low bits, auto-precharge flag set.
    always_comb begin
        rd_addr                = '0;
        rd_addr[COL_W-1:0]     = rd_col_in;
        rd_addr[AP_BIT]        = 1'b1;
    end

    // Command, address and read-issued strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd       <= CMD_NOP;
            cmd_bank  <= '0;
            cmd_addr  <= '0;
            rd_strobe <= 1'b0;
            rd_bank   <= '0;
            rd_col    <= '0;
        end else if (do_act) begin
            cmd       <= CMD_ACT;
            cmd_bank  <= act_bank;
            cmd_addr  <= act_row;
            rd_strobe <= 1'b0;
            rd_bank   <= '0;
            rd_col    <= '0;
        end else if (do_rd) begin
            cmd       <= CMD_RDA;
            cmd_bank  <= rd_bank_in;
            cmd_addr  <= rd_addr;
            rd_strobe <= 1'b1;
            rd_bank   <= rd_bank_in;
            rd_col    <= rd_col_in;
        end else begin
            cmd       <= CMD_NOP;
            cmd_bank  <= '0;
            cmd_addr  <= '0;
            rd_strobe <= 1'b0;
            rd_bank   <= '0;
            rd_col    <= '0;
        end
    end

endmodule

// File: rtl/sdram_rot_seq.sv
// sdram_rot_seq: top of the rotating-bank read sequencer.
// Activate slots and read slots alternate. Each activate slot pushes one queue
// entry (a hole if no request was taken, or while draining). A read slot pops
// once the queue holds NUM_BANKS-1 entries, which places every READ five
// cycles after its ACTIVATE when NUM_BANKS is 4. Assumes an initialized
// memory whose timing fits this spacing.
module sdram_rot_seq #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int COL_W     = 9,
    parameter int AP_BIT    = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          stop,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [ADDR_W-1:0]             req_row,
    input  logic [COL_W-1:0]              req_col,
    output logic [1:0]                    cmd,
    output logic [$clog2(NUM_BANKS)-1:0]  cmd_bank,
    output logic [ADDR_W-1:0]             cmd_addr,
    output logic                          rd_strobe,
    output logic [$clog2(NUM_BANKS)-1:0]  rd_bank,
    output logic [COL_W-1:0]              rd_col
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int CNT_W  = $clog2(NUM_BANKS + 1);
    localparam logic [CNT_W-1:0] LEAD = CNT_W'(NUM_BANKS - 1);

    logic              act_slot;
    logic              rd_slot;
    logic              take_ok;
    logic              end_run;
    logic [BANK_W-1:0] act_bank;
    logic [CNT_W-1:0]  q_count;
    logic              head_vld;
    logic [BANK_W-1:0] head_bank;
    logic [COL_W-1:0]  head_col;
    logic              drained_next;
    logic              accept;
    logic              pop;
    logic              do_rd;

    // Handshake and slot decisions for this cycle.
    always_comb begin
        req_ready = take_ok;
        accept    = take_ok && req_valid;
        pop       = rd_slot && (q_count == LEAD);
        do_rd     = pop && head_vld;
    end

    seq_slot_ctrl #(
        .NUM_BANKS (NUM_BANKS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .stop         (stop),
        .drained_next (drained_next),
        .act_slot     (act_slot),
        .rd_slot      (rd_slot),
        .take_ok      (take_ok),
        .end_run      (end_run),
        .act_bank     (act_bank)
    );

    seq_col_queue #(
        .DEPTH  (NUM_BANKS),
        .COL_W  (COL_W),
        .BANK_W (BANK_W)
    ) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (end_run),
        .push         (act_slot),
        .push_vld     (accept),
        .push_bank    (act_bank),
        .push_col     (req_col),
        .pop          (pop),
        .count        (q_count),
        .head_vld     (head_vld),
        .head_bank    (head_bank),
        .head_col     (head_col),
        .drained_next (drained_next)
    );

    seq_cmd_out #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .BANK_W (BANK_W),
        .AP_BIT (AP_BIT)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_act     (accept),
        .act_bank   (act_bank),
        .act_row    (req_row),
        .do_rd      (do_rd),
        .rd_bank_in (head_bank),
        .rd_col_in  (head_col),
        .cmd        (cmd),
        .cmd_bank   (cmd_bank),
        .cmd_addr   (cmd_addr),
        .rd_strobe  (rd_strobe),
        .rd_bank    (rd_bank),
        .rd_col     (rd_col)
    );

endmodule

// File: rtl/seq_rot_chk.sv
// seq_rot_chk: port-level properties of the rotating sequencer, bound to the top.
module seq_rot_chk #(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_row,
    input logic [1:0]        cmd,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              rd_strobe,
    input logic [BANK_W-1:0] rd_bank,
    input logic [COL_W-1:0]  rd_col
);

    p_ready_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    p_act_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd == 2'd1 && cmd_addr == $past(req_row)));

    p_act_needs_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1) |-> $past(req_valid && req_ready));

    p_read_ap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd2) |-> cmd_addr[AP_BIT]);

    p_read_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd2) |=> (cmd != 2'd2));

    p_strobe_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> (cmd == 2'd2 && rd_bank == cmd_bank && rd_col == cmd_addr[COL_W-1:0]));

    p_read_strobed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd2) |-> rd_strobe);

endmodule

bind sdram_rot_seq seq_rot_chk #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .BANK_W ($clog2(NUM_BANKS)),
    .AP_BIT (AP_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_row   (req_row),
    .cmd       (cmd),
    .cmd_bank  (cmd_bank),
    .cmd_addr  (cmd_addr),
    .rd_strobe (rd_strobe),
    .rd_bank   (rd_bank),
    .rd_col    (rd_col)
);

// File: tb/tb_sdram_rot_seq.sv
module tb_sdram_rot_seq;

    localparam int NB = 4;
    localparam int AW = 13;
    localparam int CW = 9;
    localparam int AP = 10;
    localparam int NMAX = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [1:0]    cmd;
    logic [1:0]    cmd_bank;
    logic [AW-1:0] cmd_addr;
    logic          rd_strobe;
    logic [1:0]    rd_bank;
    logic [CW-1:0] rd_col;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int t_cmd  [NMAX];
    int t_bank [NMAX];
    int t_addr [NMAX];
    int t_stb  [NMAX];
    int t_rbank[NMAX];
    int t_rcol [NMAX];
    int t_rdy  [NMAX];

    always #10 clk = ~clk;

    sdram_rot_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_row   (req_row),
        .req_col   (req_col),
        .cmd       (cmd),
        .cmd_bank  (cmd_bank),
        .cmd_addr  (cmd_addr),
        .rd_strobe (rd_strobe),
        .rd_bank   (rd_bank),
        .rd_col    (rd_col)
    );

    function automatic int row_of(int i);
        return (i * 37 + 5) % 8192;
    endfunction

    function automatic int col_of(int i);
        return (i * 11 + 3) % 512;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int k, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s sample %0d: actual %h expected %h", tag, what, k, act, exp);
        end
    endtask

    // Drives one session: start at sample 0, optional stop, hole and extra start.
    task automatic run_seq(input int n, input int stop_s, input int hole_req, input int xstart_s);
        int  idx = 0;
        bit  acc_prev = 1'b0;
        bit  holed = 1'b0;
        bit  hold;
        @(negedge clk);
        start = 1'b1;
        req_valid = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            start = (k == xstart_s);
            stop  = (k == stop_s);
            if (acc_prev) idx++;
            hold = (idx == hole_req) && !holed;
            req_valid = !hold;
            req_row = AW'(row_of(idx));
            req_col = CW'(col_of(idx));
            t_cmd[k]   = int'(cmd);
            t_bank[k]  = int'(cmd_bank);
            t_addr[k]  = int'(cmd_addr);
            t_stb[k]   = int'(rd_strobe);
            t_rbank[k] = int'(rd_bank);
            t_rcol[k]  = int'(rd_col);
            t_rdy[k]   = int'(req_ready);
            acc_prev = req_ready && req_valid;
            if (hold && req_ready) holed = 1'b1;
        end
        start = 1'b0;
        stop = 1'b0;
        req_valid = 1'b0;
    endtask

    // Compares a recorded session with the schedule implied by the requirements.
    task automatic check_trace(input int n, input int stop_s, input int hslot, input string scen);
        int sd, d, a, l, j, m, ri, ec, eb, ea, ecmd, rdy_exp;
        string tag;
        if (stop_s > 0) begin
            sd = stop_s - 1;
            d = (sd % 2 == 0) ? sd + 1 : sd + 2;
        end else begin
            d = 1000;
        end
        a = (d + 1) / 2;
        l = 2 * a + 3;
        for (int k = 1; k <= n; k++) begin
            // ready observed at sample k belongs to decision k-1
            rdy_exp = ((k - 1) % 2 == 0 && (k - 1) < d && (k - 1) <= l) ? 1 : 0;
            chk(t_rdy[k] == rdy_exp, "R7", {scen, " ready"}, k, t_rdy[k], rdy_exp);
            j = k - 2;
            ec = 0; eb = 0; ea = 0;
            tag = "R2";
            if (j < 0) begin
                tag = "R2";
            end else if (j > l) begin
                tag = "R9";
            end else if (j % 2 == 0 && j < d) begin
                m = j / 2;
                if (m == hslot) begin
                    tag = "R8";
                end else begin
                    ri = (hslot >= 0 && m > hslot) ? m - 1 : m;
                    ec = 1; eb = m % NB; ea = row_of(ri); tag = "R4";
                end
            end else if (j % 2 == 1 && j >= 5) begin
                m = (j - 5) / 2;
                if (m < a && m != hslot) begin
                    ri = (hslot >= 0 && m > hslot) ? m - 1 : m;
                    ec = 2; eb = m % NB; ea = (1 << AP) | col_of(ri); tag = "R5";
                end else if (m == hslot) begin
                    tag = "R8";
                end else begin
                    tag = "R9";
                end
            end else if (j >= d) begin
                tag = "R9";
            end else if (j >= 5) begin
                tag = "R3";
            end
            ecmd = (ec << 20) | (eb << 16) | ea;
            chk(((t_cmd[k] << 20) | (t_bank[k] << 16) | t_addr[k]) == ecmd, tag,
                {scen, " cmd/bank/addr"}, k, (t_cmd[k] << 20) | (t_bank[k] << 16) | t_addr[k], ecmd);
            chk(((t_stb[k] << 20) | (t_rbank[k] << 16) | t_rcol[k]) ==
                ((ec == 2) ? ((1 << 20) | (eb << 16) | (ea & 511)) : 0), "R6",
                {scen, " strobe/bank/col"}, k, (t_stb[k] << 20) | (t_rbank[k] << 16) | t_rcol[k],
                (ec == 2) ? ((1 << 20) | (eb << 16) | (ea & 511)) : 0);
        end
    endtask

    task automatic idle_gap(input int c);
        repeat (c) @(negedge clk);
    endtask

    // R1: reset and idle state.
    task automatic t_reset_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd == 2'd0 && cmd_bank == 0 && cmd_addr == 0, "R1", "cmd in reset", 0, int'(cmd), 0);
        chk(!req_ready && !rd_strobe, "R1", "ready/strobe in reset", 0, int'({req_ready, rd_strobe}), 0);
        rst_n = 1'b1;
        idle_gap(3);
        chk(cmd == 2'd0 && cmd_addr == 0, "R1", "cmd idle", 0, int'(cmd), 0);
        chk(!req_ready && !rd_strobe, "R1", "ready/strobe idle", 0, int'({req_ready, rd_strobe}), 0);
    endtask

    // R2 R3: fill then long steady run, stop seen in a read slot.
    task automatic t_steady_stop_rd();
        run_seq(50, 30, -1, 0);
        check_trace(50, 30, -1, "steady/stop-rd");
        idle_gap(2);
    endtask

    // R9: stop seen in an activate slot.
    task automatic t_stop_act();
        run_seq(40, 21, -1, 0);
        check_trace(40, 21, -1, "stop-act");
        idle_gap(2);
    endtask

    // R8: one request withheld for a single ready slot.
    task automatic t_hole();
        run_seq(50, 27, 2, 0);
        check_trace(50, 27, 2, "hole");
        idle_gap(2);
    endtask

    // R9: stop in the first cycle of the fill.
    task automatic t_early_stop();
        run_seq(20, 1, -1, 0);
        check_trace(20, 1, -1, "early-stop");
        idle_gap(2);
    endtask

    // R10: stop while idle, then a redundant start mid-session.
    task automatic t_ignored_ctrl();
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(cmd == 2'd0 && !req_ready, "R10", "idle after stray stop", 0, int'(cmd), 0);
        run_seq(40, 19, -1, 9);
        check_trace(40, 19, -1, "R10 ignored-start");
        idle_gap(2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        t_reset_idle();
        t_steady_stop_rd();
        t_stop_act();
        t_hole();
        t_early_stop();
        t_ignored_ctrl();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule